// File: doc/BRIEF.md
# Real-Time Clock Sub-Second Prescaler

This block sits between a 128 Hz tick source and the seconds counter of a real-time clock. Every cycle in which the tick enable is high, a seven-stage binary divider advances by one. Its stages run from 64 Hz at the least significant bit to 1 Hz at the most significant. When the divider wraps, a single-cycle carry goes to the seconds counter.

Software sees the divider through a small synchronous register bus. Reads return data through a combinational multiplexer. The divider value can be read but not written.

A read can fall in the same cycle as a tick advancing the divider. The value returned in that case may be stale, so the block sets a sticky collision flag. Software clears the flag by writing zero to it, and should then read the divider again. A control register holds two self-clearing command bits, either of which forces every divider stage back to zero.

Top module: `subsec_prescaler`

## Requirements
- R1: The divider count (address 0, bits 6:0) increases by one at each clock edge where `tick_128` is high, and holds where it is low.
- R2: When a tick arrives at count 0x7F, the count wraps to 0x00, and `sec_carry` is high for exactly the one cycle that follows that edge.
- R3: Bit 7 of address 0 always reads 0. Writes to address 0 leave the count unchanged.
- R4: A read of address 0 in a cycle where `tick_128` is high returns the count from before the advance. It sets the collision flag (address 1, bit 0) at that edge. A read of address 0 without a tick leaves the flag unchanged.
- R5: The collision flag stays at 1 until a write to address 1 with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 has no effect.
- R6: A write to address 2 with bit 1 (clear) or bit 2 (align) set zeroes all divider stages at that edge, even if a tick is present. No carry is produced by that edge.
- R7: Address 2 resets to 0x09. Bits 1 and 2 always read as 0. Every other bit reads back the last value written to it.
- R8: After reset, the count is 0, the collision flag is 0 and `sec_carry` is 0.
- R9: Bits 7:1 of address 1 and all bits of address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_128 | input | 1 | 128 Hz advance enable, one cycle per tick |
| bus_addr | input | 2 | Register select: 0 = divider, 1 = flag, 2 = control, 3 = unused |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, a combinational function of `bus_addr` |
| sec_carry | output | 1 | One-cycle pulse after the divider wraps |

## Verification
Two events can land on the same clock edge: the divider advancing on a tick, and a bus read of the divider. The bench provokes this by raising `tick_128` together with a divider read. It expects the returned byte to equal the count from before the advance, and it expects a later read of address 1 to show the flag set. A second pairing is a clear or align command issued on the same edge as a tick, including a tick at count 0x7F. There the bench expects a zero count and no carry pulse.

// File: rtl/subsec_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the sub-second prescaler.
// Assumes a 2-bit register address space and 8-bit data.
package subsec_pkg;
    localparam int ADDR_W    = 2;
    localparam int DATA_W    = 8;
    localparam int FLAG_BIT  = 0;
    localparam int CLR_BIT   = 1;
    localparam int ALIGN_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV   = 2'd0,
        REG_FLAG  = 2'd1,
        REG_CTRL  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/subsec_divider.sv
`timescale 1ns/1ps
// Ripple-enable binary divider with STAGES toggle stages.
// Stage g toggles when the tick is present and all lower stages are 1.
// A clear request overrides the tick and suppresses the carry.
// Assumes clear and tick are synchronous to clk.
module subsec_divider #(
    parameter int STAGES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    output logic [STAGES-1:0] count,
    output logic              carry_out
);
    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    logic [STAGES:0]   en;
    logic [STAGES-1:0] nxt;
    logic [STAGES-1:0] q;
    logic              carry_q;

    assign en[0] = tick;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // enable chain and toggle value for one stage
            assign en[g+1] = en[g] & q[g];
            assign nxt[g]  = q[g] ^ en[g];
        end
    endgenerate

    // divider state register with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (clear) q <= '0;
        else            q <= nxt;
    end

    // registered wrap pulse toward the seconds counter
    always_ff @(posedge clk) begin
        if (!rst_n) carry_q <= 1'b0;
        else        carry_q <= en[STAGES] & ~clear;
    end

    assign count     = q;
    assign carry_out = carry_q;

    AST_DIV_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (count == $past(count) + ONE));            // R1
    AST_DIV_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));                          // R1
    AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !carry_out));                         // R6
    AST_CARRY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |=> !carry_out);                                      // R2
    AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (count == '0 && $past(count) == '1));             // R2
endmodule

// File: rtl/subsec_collision.sv
`timescale 1ns/1ps
// Sticky flag marking a divider read that coincided with a tick.
// Hardware set wins over a software clear in the same cycle.
// Assumes set and clear are single-cycle strobes.
module subsec_collision (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_div,
    input  logic tick,
    input  logic clr_wr,
    input  logic clr_val,
    output logic flag
);
    logic set_now;
    logic flag_q;

    assign set_now = rd_div & tick;

    // sticky flag, set by collision, cleared only by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (set_now)           flag_q <= 1'b1;
        else if (clr_wr && !clr_val) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    AST_FLAG_SET:    assert property (@(posedge clk) disable iff (!rst_n)
        (rd_div && tick) |=> flag);                                     // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(clr_wr && !clr_val)) |=> flag);                      // R5
    AST_FLAG_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(rd_div && tick)) |=> !flag);                        // R4
endmodule

// File: rtl/subsec_ctrl.sv
`timescale 1ns/1ps
// Control register: plain stored bits plus two self-clearing commands.
// Either command bit in a write requests a divider clear on that edge.
// Assumes the reset value does not set the command bits.
module subsec_ctrl
    import subsec_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              div_clear,
    output logic [DATA_W-1:0] ctrl_rd
);
    localparam logic [DATA_W-1:0] PULSE_MASK =
        DATA_W'((1 << CLR_BIT) | (1 << ALIGN_BIT));

    logic [DATA_W-1:0] store_q;

    // command decode, effective at the edge closing the write cycle
    assign div_clear = wr & (wdata[CLR_BIT] | wdata[ALIGN_BIT]);

    // stored bits, command bits never retained
    always_ff @(posedge clk) begin
        if (!rst_n)  store_q <= RST_VAL & ~PULSE_MASK;
        else if (wr) store_q <= wdata & ~PULSE_MASK;
    end

    assign ctrl_rd = store_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ctrl_rd == ($past(wdata) & ~PULSE_MASK)));              // R7
    AST_CTRL_KEEP:  assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl_rd));                                      // R7
endmodule

// File: rtl/subsec_prescaler.sv
`timescale 1ns/1ps
// Top of the sub-second prescaler: divider, collision flag, control
// register and a combinational read multiplexer.
// Assumes one bus access per cycle and STAGES < DATA_W.
module subsec_prescaler
    import subsec_pkg::*;
#(
    parameter int                STAGES   = 7,
    parameter logic [DATA_W-1:0] CTRL_RST = 8'h09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_128,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sec_carry
);
    localparam int PAD_W = DATA_W - STAGES;

    logic [STAGES-1:0] count;
    logic              div_clear;
    logic              flag;
    logic [DATA_W-1:0] ctrl_rd;
    logic              sel_div, sel_flag, sel_ctrl;

    // address decode
    assign sel_div  = (bus_addr == REG_DIV);
    assign sel_flag = (bus_addr == REG_FLAG);
    assign sel_ctrl = (bus_addr == REG_CTRL);

    subsec_divider #(.STAGES(STAGES)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_128),
        .clear     (div_clear),
        .count     (count),
        .carry_out (sec_carry)
    );

    subsec_collision u_coll (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_div  (bus_rd & sel_div),
        .tick    (tick_128),
        .clr_wr  (bus_wr & sel_flag),
        .clr_val (bus_wdata[FLAG_BIT]),
        .flag    (flag)
    );

    subsec_ctrl #(.RST_VAL(CTRL_RST)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr & sel_ctrl),
        .wdata     (bus_wdata),
        .div_clear (div_clear),
        .ctrl_rd   (ctrl_rd)
    );

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_DIV:   bus_rdata = {{PAD_W{1'b0}}, count};
            REG_FLAG:  bus_rdata[FLAG_BIT] = flag;
            REG_CTRL:  bus_rdata = ctrl_rd;
            default:   bus_rdata = '0;
        endcase
    end

    AST_TOP_PAD:   assert property (@(posedge clk) disable iff (!rst_n)
        sel_div |-> (bus_rdata[DATA_W-1] == 1'b0));                     // R3
    AST_TOP_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_SPARE) |-> (bus_rdata == '0));                 // R9
    AST_TOP_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> (count == '0 && !flag && !sec_carry));         // R8
endmodule

// File: tb/subsec_prescaler_bench.sv
`timescale 1ns/1ps
module subsec_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_128 = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sec_carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // reference model state, derived from the requirements
    logic [6:0] m_cnt = '0;
    logic       m_flag = 1'b0;
    logic [7:0] m_ctrl = 8'h09;
    logic       m_carry = 1'b0;

    always #5 clk = ~clk;

    subsec_prescaler u_subsec_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_128  (tick_128),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sec_carry (sec_carry)
    );

    // model update at each edge from the inputs of the closing cycle
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_flag = 1'b0; m_ctrl = 8'h09; m_carry = 1'b0;
        end else begin
            logic clr;
            clr = bus_wr && bus_addr == 2'd2 && (bus_wdata[1] || bus_wdata[2]);
            m_carry = tick_128 && m_cnt == 7'h7F && !clr;
            if (bus_rd && bus_addr == 2'd0 && tick_128) m_flag = 1'b1;
            else if (bus_wr && bus_addr == 2'd1 && !bus_wdata[0]) m_flag = 1'b0;
            if (bus_wr && bus_addr == 2'd2) m_ctrl = bus_wdata & 8'hF9;
            if (clr) m_cnt = '0;
            else if (tick_128) m_cnt = m_cnt + 7'd1;
        end
    end

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_cnt};
            2'd1:    return {7'd0, m_flag};
            2'd2:    return m_ctrl;
            default: return 8'h00;
        endcase
    endfunction

    // driver: one bus cycle, expected read data goes to the scoreboard
    task automatic cyc(input bit tk, input bit rd, input bit wr,
                       input logic [1:0] a, input logic [7:0] wd,
                       input string tag);
        @(posedge clk); #1;
        tick_128 = tk; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        if (rd) begin
            exp_t e;
            e.val = model_read(a);
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 2'd0, 8'h00, "R1");
    endtask

    // monitor: compares read data and the carry pulse mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sec_carry !== m_carry) begin
                errors++;
                $display("FAIL R2 sec_carry actual=%0b expected=%0b", sec_carry, m_carry);
            end
            if (bus_rd) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty actual=%02h expected=none", bus_rdata);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (bus_rdata !== e.val) begin
                        errors++;
                        $display("FAIL %s addr=%0d actual=%02h expected=%02h",
                                 e.tag, bus_addr, bus_rdata, e.val);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8 R7 R9: reset values
        cyc(0, 1, 0, 2'd0, 8'h00, "R8");
        cyc(0, 1, 0, 2'd1, 8'h00, "R8");
        cyc(0, 1, 0, 2'd2, 8'h00, "R7");
        cyc(0, 1, 0, 2'd3, 8'h00, "R9");
        // R1: advance with gaps
        ticks(3);
        cyc(0, 0, 0, 2'd0, 8'h00, "R1");
        cyc(0, 0, 0, 2'd0, 8'h00, "R1");
        ticks(2);
        cyc(0, 1, 0, 2'd0, 8'h00, "R1");
        // R3: write to the divider is ignored
        cyc(0, 0, 1, 2'd0, 8'hFF, "R3");
        cyc(0, 1, 0, 2'd0, 8'h00, "R3");
        // R2: run past a wrap, carry checked every cycle
        ticks(125);
        cyc(0, 1, 0, 2'd0, 8'h00, "R2");
        ticks(5);
        cyc(0, 1, 0, 2'd0, 8'h00, "R2");
        // R4: read coinciding with a tick
        cyc(1, 1, 0, 2'd0, 8'h00, "R4");
        cyc(0, 1, 0, 2'd1, 8'h00, "R4");
        cyc(0, 1, 0, 2'd0, 8'h00, "R4");
        // R5: writing 1 keeps the flag, writing 0 clears it
        cyc(0, 0, 1, 2'd1, 8'h01, "R5");
        cyc(0, 1, 0, 2'd1, 8'h00, "R5");
        cyc(0, 0, 1, 2'd1, 8'hFE, "R5");
        cyc(0, 1, 0, 2'd1, 8'h00, "R5");
        // R4: plain read without a tick leaves the flag clear
        cyc(0, 1, 0, 2'd0, 8'h00, "R4");
        cyc(0, 1, 0, 2'd1, 8'h00, "R4");
        // R6: clear command together with a tick
        ticks(9);
        cyc(1, 0, 1, 2'd2, 8'h0B, "R6");
        cyc(0, 1, 0, 2'd0, 8'h00, "R6");
        ticks(4);
        cyc(1, 0, 1, 2'd2, 8'h0D, "R6");
        cyc(0, 1, 0, 2'd0, 8'h00, "R6");
        // R6: clear at 0x7F with a tick produces no carry
        ticks(127);
        cyc(0, 1, 0, 2'd0, 8'h00, "R6");
        cyc(1, 0, 1, 2'd2, 8'h02, "R6");
        cyc(0, 1, 0, 2'd0, 8'h00, "R6");
        // R7: stored bits and command bits on readback
        cyc(0, 0, 1, 2'd2, 8'hF0, "R7");
        cyc(0, 1, 0, 2'd2, 8'h00, "R7");
        ticks(3);
        cyc(0, 0, 1, 2'd2, 8'hFF, "R7");
        cyc(0, 1, 0, 2'd2, 8'h00, "R7");
        cyc(0, 1, 0, 2'd0, 8'h00, "R6");
        cyc(0, 0, 0, 2'd0, 8'h00, "R1");
        @(posedge clk); #1;
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule